// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines and folds them into one interrupt request per CPU. Every CPU owns a private bank of mask (enable) words and pending (status) words. A source is routed to a CPU by setting its bit in that CPU's mask words. Setting the same bit in several banks routes the source to several CPUs. No edge capture, polarity choice, priority encoding or pending queue exists. A pending bit is simply the synchronised input gated by the mask. An interrupt handler reads every pending word of its bank to find the sources that are active.

Software reaches the banks through a 32-bit register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`, so a read also completes in one cycle. Each CPU has a 0x20-byte window. Inside a window the mask words come first, then the pending words, one word of each kind per 32 sources. Mask words can only be written as whole words, so changing a single bit takes a read-modify-write sequence.

The block holds no state machine. Its only sequential elements are the two-stage input synchroniser, the mask registers and the registered per-CPU request flop.

Top module: `percpu_irq_aggregator`

## Requirements
- R1: After reset every mask word and every pending word reads zero, and every `cpu_irq` bit is low.
- R2: A write to mask word `w` of CPU `c` replaces all 32 bits of that word. The word sits at byte address `c*0x20 + 4*w` and reads back the written value. Bit `b` of mask word `w` controls source `32*w + b`.
- R3: Pending word `w` of CPU `c` sits at byte address `c*0x20 + 4*(NUM_IRQ/32) + 4*w`. Bit `b` of that word reads as synchronised source `32*w + b` ANDed with the matching mask bit of that same CPU.
- R4: Writes to pending words and to unused offsets inside a window change no mask bit. Unused offsets read as zero.
- R5: `cpu_irq[c]` is a registered OR of all pending bits of CPU `c`. It rises or falls exactly one clock edge after the pending condition changes, including a change caused by a mask write.
- R6: The banks are independent. A write in one CPU's window leaves the mask, pending words and `cpu_irq` of every other CPU unchanged.
- R7: Sources are level-sensitive. `cpu_irq` stays high as long as an enabled source stays asserted, and it falls once the source is released.
- R8: Each source passes through two synchroniser flops. A change on `irq_in` shows in the pending words after two clock edges and in `cpu_irq` after three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Level-sensitive peripheral interrupt sources |
| reg_addr | input | ADDR_W | Byte address; the bits above bit 4 select the CPU window |
| reg_wr | input | 1 | Write strobe; the write happens on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_irq | output | NUM_CPU | One registered interrupt request per CPU |

## Verification
The bench steps the synchroniser and output flops edge by edge. A design with one flop too few or too many would show a pending bit or a request one cycle early or late. It writes all-ones to pending and unused offsets and then reads the masks back, so a decoder that aliases those offsets onto mask words gets caught. It enables a source in only one CPU's bank and then checks the other CPU's output and pending words. A design that shared masks across banks, or that placed source bits in the wrong word, would raise the wrong request. A randomised phase compares every pending word and request against a model of the masks and inputs.

// File: rtl/agg_pkg.sv
package agg_pkg;

    localparam int WORD_W  = 32;
    localparam int WIN_LSB = 5;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ENABLE,
        KIND_STATUS
    } reg_kind_e;

    // Classify a word slot inside one CPU window holding nw words of each kind.
    function automatic reg_kind_e decode_kind(input logic [2:0] slot, input logic [2:0] nw);
        if (slot < nw) begin
            return KIND_ENABLE;
        end else if (3'(slot - nw) < nw) begin
            return KIND_STATUS;
        end
        return KIND_NONE;
    endfunction

endpackage

// File: rtl/agg_sync.sv
module agg_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/agg_bank.sv
module agg_bank
    import agg_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_s,
    input  logic               en_we,
    input  logic [2:0]         en_idx,
    input  logic [WORD_W-1:0]  wdata,
    output logic [NUM_IRQ-1:0] en_vec,
    output logic [NUM_IRQ-1:0] stat_vec,
    output logic               irq_o
);

    localparam int NW = NUM_IRQ / WORD_W;

    // One whole-word mask register per 32 sources
    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WORD_W-1:0] mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (en_we && (en_idx == 3'(w))) begin
                mask_q <= wdata;
            end
        end

        assign en_vec[w*WORD_W +: WORD_W] = mask_q;
    end

    assign stat_vec = irq_s & en_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |stat_vec;
        end
    end

endmodule

// File: rtl/agg_rdmux.sv
module agg_rdmux
    import agg_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input  logic [CPU_W-1:0]           cpu_sel,
    input  reg_kind_e                  kind,
    input  logic [2:0]                 en_slot,
    input  logic [2:0]                 st_slot,
    input  logic [NUM_CPU*NUM_IRQ-1:0] en_all,
    input  logic [NUM_CPU*NUM_IRQ-1:0] stat_all,
    output logic [WORD_W-1:0]          rdata
);

    localparam int NW = NUM_IRQ / WORD_W;

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int w = 0; w < NW; w++) begin
                if ((cpu_sel == CPU_W'(c)) && (kind == KIND_ENABLE) && (en_slot == 3'(w))) begin
                    rdata = en_all[c*NUM_IRQ + w*WORD_W +: WORD_W];
                end
                if ((cpu_sel == CPU_W'(c)) && (kind == KIND_STATUS) && (st_slot == 3'(w))) begin
                    rdata = stat_all[c*NUM_IRQ + w*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/percpu_irq_aggregator.sv
module percpu_irq_aggregator
    import agg_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ADDR_W = WIN_LSB + CPU_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    localparam int         NW  = NUM_IRQ / WORD_W;
    localparam logic [2:0] NW3 = 3'(NW);

    logic [NUM_IRQ-1:0]         irq_sync;
    logic [CPU_W-1:0]           cpu_f;
    logic [2:0]                 slot_f;
    logic [2:0]                 st_slot;
    logic [1:0]                 unused_lsb;
    logic                       cpu_ok;
    reg_kind_e                  kind;
    logic [NUM_CPU*NUM_IRQ-1:0] en_flat;
    logic [NUM_CPU*NUM_IRQ-1:0] stat_flat;

    agg_sync #(.W(NUM_IRQ)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_sync)
    );

    // Address decode: window select, word slot, byte lanes unused
    assign cpu_f      = reg_addr[ADDR_W-1:WIN_LSB];
    assign slot_f     = reg_addr[4:2];
    assign unused_lsb = reg_addr[1:0];
    assign st_slot    = slot_f - NW3;

    if (NUM_CPU == (1 << CPU_W)) begin : g_cpu_full
        assign cpu_ok = 1'b1;
    end else begin : g_cpu_part
        assign cpu_ok = (cpu_f < CPU_W'(NUM_CPU));
    end

    assign kind = cpu_ok ? decode_kind(slot_f, NW3) : KIND_NONE;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        agg_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_s    (irq_sync),
            .en_we    (reg_wr && (kind == KIND_ENABLE) && (cpu_f == CPU_W'(c))),
            .en_idx   (slot_f),
            .wdata    (reg_wdata),
            .en_vec   (en_flat[c*NUM_IRQ +: NUM_IRQ]),
            .stat_vec (stat_flat[c*NUM_IRQ +: NUM_IRQ]),
            .irq_o    (cpu_irq[c])
        );
    end

    agg_rdmux #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_rdmux (
        .cpu_sel  (cpu_f),
        .kind     (kind),
        .en_slot  (slot_f),
        .st_slot  (st_slot),
        .en_all   (en_flat),
        .stat_all (stat_flat),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/agg_checker.sv
module agg_checker #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_IRQ-1:0]         irq_in,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic                       reg_wr,
    input logic [31:0]                reg_wdata,
    input logic [31:0]                reg_rdata,
    input logic [NUM_CPU-1:0]         cpu_irq,
    input logic [NUM_CPU*NUM_IRQ-1:0] en_flat,
    input logic [NUM_IRQ-1:0]         irq_sync
);

    localparam int NW = NUM_IRQ / 32;

    logic [1:0] age_q;
    logic       mask_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign mask_slot = (reg_addr[4:2] < 3'(NW));

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (irq_sync == $past(irq_in, 2)));

    // R4
    no_mask_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mask_slot) |=> $stable(en_flat));

    if (NW < 4) begin : g_unused
        // R4
        unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr[4:2] >= 3'(2*NW)) |-> (reg_rdata == 32'd0));
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // R1
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_flat[c*NUM_IRQ +: NUM_IRQ] == '0) |=> !cpu_irq[c]);

        // R5
        irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd1) |-> (cpu_irq[c] == $past(|(irq_sync & en_flat[c*NUM_IRQ +: NUM_IRQ]))));

        for (genvar w = 0; w < NW; w++) begin : g_word
            // R2
            mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(c*8 + w)))
                |=> (en_flat[c*NUM_IRQ + w*32 +: 32] == $past(reg_wdata)));
        end
    end

endmodule

bind percpu_irq_aggregator agg_checker #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W)
) u_agg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq),
    .en_flat   (en_flat),
    .irq_sync  (irq_sync)
);

// File: tb/test_percpu_irq_aggregator.sv
module test_percpu_irq_aggregator;

    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 2;
    localparam int NW      = NUM_IRQ / 32;
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int ADDR_W  = 5 + CPU_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_IRQ-1:0] irq_in = '0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic               reg_wr = 1'b0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NUM_CPU-1:0] cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [NUM_IRQ-1:0] en_m [NUM_CPU];

    always #4 clk = ~clk;

    percpu_irq_aggregator #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_percpu_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input int cpu, input int slot, input logic [31:0] data);
        reg_addr  = ADDR_W'(cpu*32 + slot*4);
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
        if (slot < NW) en_m[cpu][slot*32 +: 32] = data;
    endtask

    task automatic rd(input int cpu, input int slot, output logic [31:0] v);
        reg_addr = ADDR_W'(cpu*32 + slot*4);
        #1;
        v = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Compare every window word and request against the model
    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [NUM_IRQ-1:0] st;
        for (int c = 0; c < NUM_CPU; c++) begin
            st = irq_in & en_m[c];
            for (int w = 0; w < NW; w++) begin
                rd(c, w, v);
                check({tag, " R2 mask"}, v, en_m[c][w*32 +: 32]);
                rd(c, NW + w, v);
                check({tag, " R3 pending"}, v, st[w*32 +: 32]);
            end
            check({tag, " R5 cpu_irq"}, 32'(cpu_irq[c]), 32'(|st));
        end
    endtask

    task automatic t_reset();
        check_all("reset R1");
        check("reset R1 irq", 32'(cpu_irq), 32'd0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        wr(0, 0, 32'hA5A5_0F0F);
        wr(0, 1, 32'h1234_5678);
        wr(1, 0, 32'hFFFF_0000);
        wr(1, 1, 32'h0000_0001);
        rd(0, 0, v); check("R2 c0w0", v, 32'hA5A5_0F0F);
        rd(0, 1, v); check("R2 c0w1", v, 32'h1234_5678);
        rd(1, 0, v); check("R2 c1w0 R6", v, 32'hFFFF_0000);
        rd(1, 1, v); check("R2 c1w1 R6", v, 32'h0000_0001);
        for (int c = 0; c < NUM_CPU; c++)
            for (int w = 0; w < NW; w++) wr(c, w, 32'd0);
        settle();
        check_all("R2 cleared");
    endtask

    task automatic t_layout();
        logic [31:0] v;
        irq_in = '0;
        irq_in[33] = 1'b1;
        irq_in[2]  = 1'b1;
        wr(0, 1, 32'h0000_0002);
        settle();
        rd(0, NW + 1, v); check("R3 word1 bit1", v, 32'h0000_0002);
        rd(0, NW + 0, v); check("R3 word0 masked", v, 32'h0);
        check("R3 irq c0", 32'(cpu_irq[0]), 32'd1);
        wr(0, 1, 32'd0);
        irq_in = '0;
        settle();
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(0, 0, 32'h0000_00F0);
        wr(0, NW, 32'hFFFF_FFFF);
        wr(0, NW + 1, 32'hFFFF_FFFF);
        for (int s = 2*NW; s < 8; s++) wr(0, s, 32'hFFFF_FFFF);
        rd(0, 0, v); check("R4 mask0 kept", v, 32'h0000_00F0);
        rd(0, 1, v); check("R4 mask1 kept", v, 32'h0);
        for (int s = 2*NW; s < 8; s++) begin
            rd(0, s, v); check("R4 unused zero", v, 32'h0);
        end
        rd(1, 0, v); check("R4 R6 other bank", v, 32'h0);
        settle();
        check("R4 irq unchanged", 32'(cpu_irq), 32'd0);
        wr(0, 0, 32'd0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        wr(1, 0, 32'h0000_0010);
        settle();
        irq_in[4] = 1'b1;
        @(negedge clk);
        rd(1, NW, v); check("R8 one edge no pending", v, 32'h0);
        @(negedge clk);
        rd(1, NW, v); check("R8 two edges pending", v, 32'h10);
        check("R5 irq not yet", 32'(cpu_irq[1]), 32'd0);
        @(negedge clk);
        check("R8 R5 irq high", 32'(cpu_irq[1]), 32'd1);
        repeat (5) @(negedge clk);
        check("R7 level held", 32'(cpu_irq[1]), 32'd1);
        irq_in[4] = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R7 still high", 32'(cpu_irq[1]), 32'd1);
        @(negedge clk);
        check("R7 released", 32'(cpu_irq[1]), 32'd0);
        irq_in[4] = 1'b1;
        settle();
        check("R5 re-raised", 32'(cpu_irq[1]), 32'd1);
        wr(1, 0, 32'h0);
        rd(1, NW, v); check("R5 pending cleared", v, 32'h0);
        check("R5 irq one edge late", 32'(cpu_irq[1]), 32'd1);
        @(negedge clk);
        check("R5 irq dropped", 32'(cpu_irq[1]), 32'd0);
        irq_in = '0;
        settle();
    endtask

    task automatic t_independent();
        logic [31:0] v;
        irq_in[40] = 1'b1;
        wr(1, 1, 32'h0000_0100);
        settle();
        check("R6 c1 raised", 32'(cpu_irq[1]), 32'd1);
        check("R6 c0 quiet", 32'(cpu_irq[0]), 32'd0);
        rd(0, NW + 1, v); check("R6 c0 pending", v, 32'h0);
        wr(0, 1, 32'h0000_0100);
        @(negedge clk);
        check("R6 c0 raised", 32'(cpu_irq[0]), 32'd1);
        wr(1, 1, 32'h0);
        @(negedge clk);
        check("R6 c1 dropped", 32'(cpu_irq[1]), 32'd0);
        check("R6 c0 kept", 32'(cpu_irq[0]), 32'd1);
        wr(0, 1, 32'h0);
        irq_in = '0;
        settle();
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            for (int w = 0; w < NW; w++) irq_in[w*32 +: 32] = $urandom & $urandom;
            wr(int'($urandom_range(0, NUM_CPU-1)), int'($urandom_range(0, NW-1)),
               $urandom & $urandom & $urandom);
            settle();
            check_all("random R3 R5 R6");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CPU; c++) en_m[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_layout();
        t_ignore();
        t_timing();
        t_independent();
        t_random();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule